// File: doc/BRIEF.md
# Dual-Segment Packet Packer

The block sits on a 512-bit packet stream in which every packet begins at the top of the bus. It rewrites the stream into dual-segment form. When a packet finishes within the upper half of a beat, the next packet may begin at the midpoint word of that same beat. This removes the idle words that word-aligned packing would otherwise leave below a short tail. The bus is treated as eight 64-bit words. Word 7 (bits 511:448) goes first on the wire and word 0 goes last. Both sides of the block use valid/ready flow control.

Each output beat has two start flags, one for the top word and one for the midpoint word (word 3). It also has a single end flag and a count of the ending packet's words. The count is measured from the top of the bus. A one-bit enable selects packing. With the enable low, the output is plain word-aligned traffic. When a tail is waiting but the next packet's first beat has not arrived, the block sends the tail with an idle lower half. It does not stall waiting for more input.

Input packets are at least eight words long. The block merges only when that contract makes the spacing rules below hold.

Top module: `dseg_packer`

## Requirements
- R1: Every accepted payload word appears on the output exactly once and in input order. A top-word start marks word 7 as a packet's first word.
- R2: The count field gives how many words from the top of the bus the ending packet occupies, with 0 meaning all eight. It is used on both ports when the end flag is set. Every output word that belongs to no packet is driven to zero.
- R3: The midpoint start flag is set only in a beat whose end flag is also set with an ending count of 1 to 4. The new packet's first word is then word 3.
- R4: In any output beat, at most one of the two start flags is set. A single end flag allows at most one end.
- R5: On consecutive transferred beats, a beat after one with a midpoint start carries no top-word start. Starts are therefore at least eight words apart.
- R6: On consecutive transferred beats that both carry an end, the later ending count is at least the earlier one. Ends are therefore at least eight words apart.
- R7: While the enable is low, the midpoint start flag is never set. Each packet of L words takes exactly ceil(L/8) output beats.
- R8: A captured upper-half tail is offered on the output in the very next cycle. This holds even when no further input is present; the lower half is then idle and zero.
- R9: Input ready is low in every cycle where output ready is low. No beat is lost or duplicated under arbitrary valid and ready patterns on both sides.
- R10: Output valid is low during reset and after reset until input arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pack_en | input | 1 | Allows a midpoint start when high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted this cycle |
| in_data | input | 512 | Input beat, word 7 first |
| in_sop | input | 1 | Input beat starts a packet at word 7 |
| in_eop | input | 1 | Input beat ends a packet |
| in_cnt | input | 4 | Words in the ending beat from the top, 0 means eight |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 512 | Output beat, word 7 first, unused words zero |
| out_sop_hi | output | 1 | Packet starts at word 7 |
| out_sop_lo | output | 1 | Packet starts at word 3 |
| out_eop | output | 1 | A packet ends in this beat |
| out_cnt | output | 4 | Words of the ending packet from the top, 0 means eight |

## Verification
A vector table pairs two back-to-back packets with lengths chosen to hit each branch, with downstream always ready:
- a full-beat end that passes straight through;
- a 1-to-4-word tail that merges with a long successor;
- a tail that merges with a one-beat successor, which leaves a second tail;
- a five-word tail that must not merge;
- a last tail with nothing behind it.

Counting beats and midpoint starts for each pair tells a missed merge apart from an illegal one. The same pairs with packing off give the aligned baseline. Long random runs with gaps on the input and stalls on the output then check that the reassembled payload matches word for word. They also check every start/end rule beat by beat, with packing on and with it off.

// File: rtl/dseg_pkg.sv
package dseg_pkg;

   // Packing engine state
   typedef enum logic [1:0] {
      ST_ALIGN = 2'd0,   // no words held, input passes straight through
      ST_SHIFT = 2'd1,   // carry holds the upper part of a packet started at mid
      ST_TAIL  = 2'd2    // carry holds an ending tail of at most half a bus
   } dseg_state_e;

   // Output word source
   typedef enum logic [1:0] {
      SEL_PASS  = 2'd0,  // whole bus from the input
      SEL_JOIN  = 2'd1,  // carry in the upper half, input upper half below it
      SEL_CARRY = 2'd2,  // carry in the upper half, lower half idle
      SEL_NONE  = 2'd3
   } dseg_sel_e;

endpackage

// File: rtl/dseg_carry.sv
module dseg_carry #(
   parameter int WORD_W = 64,
   parameter int HALF   = 4,
   parameter int CNT_W  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [WORD_W*HALF-1:0] ld_data,
   input  logic [CNT_W-1:0]       ld_cnt,
   input  logic                   ld_sop,
   output logic [WORD_W*HALF-1:0] q_data,
   output logic [CNT_W-1:0]       q_cnt,
   output logic                   q_sop
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_data <= '0;
         q_cnt  <= '0;
         q_sop  <= 1'b0;
      end else if (load) begin
         q_data <= ld_data;
         q_cnt  <= ld_cnt;
         q_sop  <= ld_sop;
      end
   end

   // R2: a held segment always has between one and HALF valid words
   p_carry_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (ld_cnt != '0) && (ld_cnt <= CNT_W'(HALF)));

endmodule

// File: rtl/dseg_ctrl.sv
module dseg_ctrl
   import dseg_pkg::*;
#(
   parameter int WORDS = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pack_en,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic [CNT_W-1:0] in_cnt,
   input  logic             out_ready,
   input  logic [CNT_W-1:0] c_cnt,
   input  logic             c_sop,
   output logic             in_ready,
   output logic             out_valid,
   output dseg_sel_e        sel,
   output logic             f_sop_hi,
   output logic             f_sop_lo,
   output logic             f_eop,
   output logic [CNT_W-1:0] f_cnt,
   output logic             ld,
   output logic             ld_lo,
   output logic [CNT_W-1:0] ld_cnt,
   output logic             ld_sop
);

   localparam int HALF = WORDS / 2;
   localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);
   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(WORDS);

   dseg_state_e state, nxt;

   logic [CNT_W-1:0] in_words;
   logic [CNT_W-1:0] join_words;
   logic [CNT_W-1:0] join_code;
   logic             small_end;
   logic             merge_ok;

   assign in_words   = (in_cnt == '0) ? FULL_C : in_cnt;
   assign small_end  = in_eop && (in_words <= HALF_C);
   assign join_words = HALF_C + in_words;
   assign join_code  = (join_words == FULL_C) ? '0 : join_words;
   // a following packet may fill the lower half unless it would also end there
   assign merge_ok   = pack_en && in_valid && !small_end;

   always_comb begin
      nxt      = state;
      in_ready = 1'b0;
      out_valid = 1'b0;
      sel      = SEL_NONE;
      f_sop_hi = 1'b0;
      f_sop_lo = 1'b0;
      f_eop    = 1'b0;
      f_cnt    = '0;
      ld       = 1'b0;
      ld_lo    = 1'b0;
      ld_cnt   = '0;
      ld_sop   = 1'b0;
      unique case (state)
         ST_ALIGN: begin
            in_ready = out_ready;
            if (pack_en && in_valid && small_end) begin
               // hold the short tail back, it may share a beat with the next start
               if (out_ready) begin
                  ld     = 1'b1;
                  ld_cnt = in_words;
                  ld_sop = in_sop;
                  nxt    = ST_TAIL;
               end
            end else begin
               out_valid = in_valid;
               sel       = SEL_PASS;
               f_sop_hi  = in_sop;
               f_eop     = in_eop;
               f_cnt     = in_eop ? in_cnt : '0;
            end
         end
         ST_TAIL: begin
            out_valid = 1'b1;
            f_sop_hi  = c_sop;
            f_eop     = 1'b1;
            f_cnt     = c_cnt;
            if (merge_ok) begin
               sel      = SEL_JOIN;
               f_sop_lo = 1'b1;
               in_ready = out_ready;
               if (out_ready) begin
                  ld    = 1'b1;
                  ld_lo = 1'b1;
                  if (in_eop) begin
                     ld_cnt = in_words - HALF_C;
                     nxt    = ST_TAIL;
                  end else begin
                     ld_cnt = HALF_C;
                     nxt    = ST_SHIFT;
                  end
               end
            end else begin
               sel = SEL_CARRY;
               if (out_ready) nxt = ST_ALIGN;
            end
         end
         ST_SHIFT: begin
            in_ready  = out_ready;
            out_valid = in_valid;
            sel       = SEL_JOIN;
            if (small_end) begin
               f_eop = 1'b1;
               f_cnt = join_code;
               if (in_valid && out_ready) nxt = ST_ALIGN;
            end else if (in_valid && out_ready) begin
               ld    = 1'b1;
               ld_lo = 1'b1;
               if (in_eop) begin
                  ld_cnt = in_words - HALF_C;
                  nxt    = ST_TAIL;
               end else begin
                  ld_cnt = HALF_C;
               end
            end
         end
         default: nxt = ST_ALIGN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_ALIGN;
      else        state <= nxt;
   end

   // R3: a midpoint start only beside an end that used at most half the bus
   p_mid_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && f_sop_lo) |-> (f_eop && (f_cnt != '0) && (f_cnt <= HALF_C)));

   // R9: nothing is taken from upstream while downstream is stalled
   p_ready_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |-> !in_ready);

   // R8: a tail captured from an aligned beat is offered in the next cycle
   p_tail_emit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !ld_lo) |=> out_valid);

endmodule

// File: rtl/dseg_assemble.sv
module dseg_assemble
   import dseg_pkg::*;
#(
   parameter int WORD_W = 64,
   parameter int WORDS  = 8,
   parameter int CNT_W  = 4
) (
   input  dseg_sel_e                   sel,
   input  logic [WORD_W*WORDS-1:0]     in_data,
   input  logic [WORD_W*WORDS/2-1:0]   c_data,
   input  logic                        valid,
   input  logic                        eop,
   input  logic                        sop_lo,
   input  logic [CNT_W-1:0]            cnt,
   output logic [WORD_W*WORDS-1:0]     out_data
);

   localparam int HALF = WORDS / 2;

   logic [CNT_W-1:0] end_words;
   assign end_words = (cnt == '0) ? CNT_W'(WORDS) : cnt;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam int  FROM_TOP = WORDS - 1 - w;
      localparam bit  LOWER    = (w < HALF);
      logic [WORD_W-1:0] join_w;
      logic [WORD_W-1:0] carry_w;
      logic [WORD_W-1:0] raw;
      logic              keep;

      if (w >= HALF) begin : g_hi
         assign join_w  = c_data[(w-HALF)*WORD_W +: WORD_W];
         assign carry_w = c_data[(w-HALF)*WORD_W +: WORD_W];
      end else begin : g_lo
         assign join_w  = in_data[(w+HALF)*WORD_W +: WORD_W];
         assign carry_w = '0;
      end

      always_comb begin
         unique case (sel)
            SEL_PASS:  raw = in_data[w*WORD_W +: WORD_W];
            SEL_JOIN:  raw = join_w;
            SEL_CARRY: raw = carry_w;
            default:   raw = '0;
         endcase
      end

      // words past the end are dropped unless a new packet fills the lower half
      assign keep = !eop || (CNT_W'(FROM_TOP) < end_words) || (sop_lo && LOWER);
      assign out_data[w*WORD_W +: WORD_W] = (valid && keep) ? raw : '0;
   end

endmodule

// File: rtl/dseg_packer.sv
module dseg_packer
   import dseg_pkg::*;
#(
   parameter int WORD_W     = 64,
   parameter int WORDS      = 8,
   parameter bit ALLOW_PACK = 1'b1,
   localparam int BUS_W     = WORD_W * WORDS,
   localparam int CNT_W     = $clog2(WORDS) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pack_en,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [BUS_W-1:0] in_data,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic [CNT_W-1:0] in_cnt,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [BUS_W-1:0] out_data,
   output logic             out_sop_hi,
   output logic             out_sop_lo,
   output logic             out_eop,
   output logic [CNT_W-1:0] out_cnt
);

   localparam int HALF   = WORDS / 2;
   localparam int HALF_W = WORD_W * HALF;

   if (WORDS < 2 || (WORDS % 2) != 0) begin : g_bad_words
      $error("dseg_packer: WORDS must be even and at least 2");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("dseg_packer: WORD_W must be positive");
   end

   dseg_sel_e         sel;
   logic [HALF_W-1:0] c_data;
   logic [CNT_W-1:0]  c_cnt;
   logic              c_sop;

   if (ALLOW_PACK) begin : g_pack
      logic              ld;
      logic              ld_lo;
      logic [CNT_W-1:0]  ld_cnt;
      logic              ld_sop;
      logic [HALF_W-1:0] ld_data;

      assign ld_data = ld_lo ? in_data[HALF_W-1:0] : in_data[BUS_W-1 -: HALF_W];

      dseg_ctrl #(.WORDS(WORDS), .CNT_W(CNT_W)) u_ctrl (
         .clk       (clk),
         .rst_n     (rst_n),
         .pack_en   (pack_en),
         .in_valid  (in_valid),
         .in_sop    (in_sop),
         .in_eop    (in_eop),
         .in_cnt    (in_cnt),
         .out_ready (out_ready),
         .c_cnt     (c_cnt),
         .c_sop     (c_sop),
         .in_ready  (in_ready),
         .out_valid (out_valid),
         .sel       (sel),
         .f_sop_hi  (out_sop_hi),
         .f_sop_lo  (out_sop_lo),
         .f_eop     (out_eop),
         .f_cnt     (out_cnt),
         .ld        (ld),
         .ld_lo     (ld_lo),
         .ld_cnt    (ld_cnt),
         .ld_sop    (ld_sop)
      );

      dseg_carry #(.WORD_W(WORD_W), .HALF(HALF), .CNT_W(CNT_W)) u_carry (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (ld),
         .ld_data (ld_data),
         .ld_cnt  (ld_cnt),
         .ld_sop  (ld_sop),
         .q_data  (c_data),
         .q_cnt   (c_cnt),
         .q_sop   (c_sop)
      );
   end else begin : g_plain
      assign in_ready   = out_ready;
      assign out_valid  = in_valid;
      assign sel        = SEL_PASS;
      assign out_sop_hi = in_sop;
      assign out_sop_lo = 1'b0;
      assign out_eop    = in_eop;
      assign out_cnt    = in_eop ? in_cnt : '0;
      assign c_data     = '0;
      assign c_cnt      = '0;
      assign c_sop      = 1'b0;
   end

   dseg_assemble #(.WORD_W(WORD_W), .WORDS(WORDS), .CNT_W(CNT_W)) u_asm (
      .sel      (sel),
      .in_data  (in_data),
      .c_data   (c_data),
      .valid    (out_valid),
      .eop      (out_eop),
      .sop_lo   (out_sop_lo),
      .cnt      (out_cnt),
      .out_data (out_data)
   );

   // History of the last transferred beat, for the spacing checks
   logic             out_fire;
   logic [CNT_W-1:0] out_words;
   logic             last_lo;
   logic             last_eop;
   logic [CNT_W-1:0] last_end;

   assign out_fire  = out_valid && out_ready;
   assign out_words = (out_cnt == '0) ? CNT_W'(WORDS) : out_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_lo  <= 1'b0;
         last_eop <= 1'b0;
         last_end <= '0;
      end else if (out_fire) begin
         last_lo  <= out_sop_lo;
         last_eop <= out_eop;
         last_end <= out_words;
      end
   end

   // R4: one start position per beat
   p_one_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_sop_hi && out_sop_lo));

   // R5: a midpoint start is never followed by a top start in the next beat
   p_start_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && last_lo) |-> !out_sop_hi);

   // R6: two ends on consecutive beats are a full bus apart
   p_end_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fire && out_eop && last_eop) |-> (out_words >= last_end));

   // R7: packing disabled means no midpoint start
   p_pack_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !pack_en) |-> !out_sop_lo);

endmodule

// File: tb/dseg_packer_test.sv
module dseg_packer_test;

   localparam int CLK_P  = 10;
   localparam int WORD_W = 64;
   localparam int WORDS  = 8;
   localparam int CNT_W  = 4;
   localparam int BUS_W  = WORD_W * WORDS;

   typedef struct packed {
      int len_a;
      int len_b;
      int pk;
      int beats;
      int lo;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VEC [NVEC] = '{
      '{8,  8,  1, 2, 0},   // full beats pass straight through
      '{12, 8,  1, 3, 1},   // tail merges with one-beat packet, leaves a second tail
      '{12, 12, 1, 3, 1},   // tail merges, shifted packet ends in lower half
      '{9,  9,  1, 3, 1},   // one-word tails
      '{13, 8,  1, 3, 0},   // five-word tail must not merge
      '{12, 12, 0, 4, 0},   // packing off: aligned baseline
      '{12, 15, 1, 4, 1},   // shifted packet leaves a three-word tail
      '{16, 12, 1, 4, 0},   // last tail has nothing behind it
      '{20, 8,  1, 4, 1}    // merge after two full beats
   };

   logic             clk;
   logic             rst_n;
   logic             pack_en;
   logic             in_valid;
   logic             in_ready;
   logic [BUS_W-1:0] in_data;
   logic             in_sop;
   logic             in_eop;
   logic [CNT_W-1:0] in_cnt;
   logic             out_valid;
   logic             out_ready;
   logic [BUS_W-1:0] out_data;
   logic             out_sop_hi;
   logic             out_sop_lo;
   logic             out_eop;
   logic [CNT_W-1:0] out_cnt;

   dseg_packer #(.WORD_W(WORD_W), .WORDS(WORDS)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pack_en    (pack_en),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_data    (in_data),
      .in_sop     (in_sop),
      .in_eop     (in_eop),
      .in_cnt     (in_cnt),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_data   (out_data),
      .out_sop_hi (out_sop_hi),
      .out_sop_lo (out_sop_lo),
      .out_eop    (out_eop),
      .out_cnt    (out_cnt)
   );

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   int tests = 0;
   int fails = 0;
   int pkt_id = 0;
   bit rnd_ready = 1'b0;

   logic [WORD_W-1:0] exp_q[$];
   int                len_q[$];

   // monitor state
   bit in_pkt = 1'b0;
   int cur_len = 0;
   int cur_bad = 0;
   bit prev_lo = 1'b0;
   bit prev_eop = 1'b0;
   int prev_end = 0;
   int nbeats = 0;
   int nlo = 0;
   int r3_err = 0, r4_err = 0, r5_err = 0, r6_err = 0, r7_err = 0, r9_err = 0;
   int zero_err = 0, frame_err = 0;

   function automatic logic [WORD_W-1:0] mkword(input int id, input int i);
      return {32'(id) + 32'h100, 16'(i), 16'hC3A5};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   always @(negedge clk) out_ready <= rnd_ready ? (($urandom % 3) != 0) : 1'b1;

   // monitor: samples one unit before each rising edge
   always @(negedge clk) begin : mon
      int cw;
      logic [WORD_W-1:0] word;
      logic [WORD_W-1:0] expw;
      #(CLK_P/2 - 1);
      if (rst_n) begin
         if (in_ready && !out_ready) r9_err++;
         if (out_valid && out_ready) begin
            cw = (out_cnt == '0) ? WORDS : int'(out_cnt);
            if (out_sop_hi && out_sop_lo) r4_err++;
            if (out_sop_lo && !(out_eop && cw <= WORDS/2)) r3_err++;
            if (out_sop_lo && !pack_en) r7_err++;
            if (prev_lo && out_sop_hi) r5_err++;
            if (prev_eop && out_eop && cw < prev_end) r6_err++;
            for (int w = WORDS - 1; w >= 0; w--) begin
               word = out_data[w*WORD_W +: WORD_W];
               if ((w == WORDS - 1 && out_sop_hi) || (w == WORDS/2 - 1 && out_sop_lo)) begin
                  if (in_pkt) frame_err++;
                  in_pkt = 1'b1;
                  cur_len = 0;
                  cur_bad = 0;
               end
               if (in_pkt) begin
                  if (exp_q.size() > 0) expw = exp_q.pop_front();
                  else expw = '0;
                  if (word !== expw) cur_bad++;
                  cur_len++;
                  if (out_eop && (WORDS - w) == cw) begin
                     int el;
                     el = (len_q.size() > 0) ? len_q.pop_front() : -1;
                     check(cur_bad == 0 && cur_len == el, "R1 packet payload/length", cur_len, el);
                     if (cur_bad != 0) $display("FAIL R1 %0d mismatched words in packet", cur_bad);
                     in_pkt = 1'b0;
                  end
               end else if (word != '0) begin
                  zero_err++;
               end
            end
            prev_lo = out_sop_lo;
            prev_eop = out_eop;
            prev_end = cw;
            nbeats++;
            if (out_sop_lo) nlo++;
         end
      end
   end

   task automatic send_pkt(input int len, input bit gaps);
      int id;
      int nb;
      id = pkt_id;
      pkt_id++;
      for (int i = 0; i < len; i++) exp_q.push_back(mkword(id, i));
      len_q.push_back(len);
      nb = (len + WORDS - 1) / WORDS;
      for (int b = 0; b < nb; b++) begin
         if (gaps && ($urandom % 4) == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
         do begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop = (b == 0);
            in_eop = (b == nb - 1);
            in_cnt = in_eop ? CNT_W'((len - b*WORDS) % WORDS) : '0;
            for (int w = 0; w < WORDS; w++) begin
               int idx;
               idx = b*WORDS + (WORDS - 1 - w);
               in_data[w*WORD_W +: WORD_W] = (idx < len) ? mkword(id, idx) : '0;
            end
            #(CLK_P/2 - 1);
         end while (!in_ready);
      end
   endtask

   task automatic go_idle(input int cycles);
      @(negedge clk);
      in_valid = 1'b0;
      in_sop = 1'b0;
      in_eop = 1'b0;
      in_cnt = '0;
      in_data = '0;
      repeat (cycles) @(negedge clk);
   endtask

   initial begin
      #(CLK_P * 100000);
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      int b0, l0, sum_beats;
      rst_n = 1'b0;
      pack_en = 1'b1;
      in_valid = 1'b0;
      in_sop = 1'b0;
      in_eop = 1'b0;
      in_cnt = '0;
      in_data = '0;
      repeat (3) @(negedge clk);
      #(CLK_P/2 - 1);
      check(out_valid == 1'b0, "R10 valid during reset", int'(out_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #(CLK_P/2 - 1);
      check(out_valid == 1'b0, "R10 valid after reset", int'(out_valid), 0);

      // table of paired packets, downstream always ready
      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk);
         pack_en = VEC[v].pk[0];
         b0 = nbeats;
         l0 = nlo;
         send_pkt(VEC[v].len_a, 1'b0);
         send_pkt(VEC[v].len_b, 1'b0);
         go_idle(8);
         check(nbeats - b0 == VEC[v].beats, $sformatf("R8 beats for pair %0d", v), nbeats - b0, VEC[v].beats);
         check(nlo - l0 == VEC[v].lo, $sformatf("R3 midpoint starts for pair %0d", v), nlo - l0, VEC[v].lo);
      end

      // random lengths, input gaps, output stalls, packing on
      rnd_ready = 1'b1;
      pack_en = 1'b1;
      for (int p = 0; p < 60; p++) send_pkt(8 + int'($urandom % 17), 1'b1);
      go_idle(30);

      // packing off under the same kind of traffic
      b0 = nbeats;
      l0 = nlo;
      sum_beats = 0;
      pack_en = 1'b0;
      for (int p = 0; p < 20; p++) begin
         int len;
         len = 8 + int'($urandom % 17);
         sum_beats += (len + WORDS - 1) / WORDS;
         send_pkt(len, 1'b1);
      end
      go_idle(30);
      check(nlo == l0, "R7 no midpoint start when off", nlo - l0, 0);
      check(nbeats - b0 == sum_beats, "R7 aligned beat count", nbeats - b0, sum_beats);

      check(r3_err == 0, "R3 midpoint start beside short end", r3_err, 0);
      check(r4_err == 0, "R4 two starts in a beat", r4_err, 0);
      check(r5_err == 0, "R5 start spacing", r5_err, 0);
      check(r6_err == 0, "R6 end spacing", r6_err, 0);
      check(r7_err == 0, "R7 midpoint start while off", r7_err, 0);
      check(r9_err == 0, "R9 ready while stalled", r9_err, 0);
      check(zero_err == 0, "R2 unused words zero", zero_err, 0);
      check(frame_err == 0 && !in_pkt, "R1 framing", frame_err, 0);
      check(exp_q.size() == 0, "R9 words not delivered", exp_q.size(), 0);
      check(len_q.size() == 0, "R9 packets not delivered", len_q.size(), 0);

      summary();
      $finish;
   end

endmodule